// File: doc/BRIEF.md
# Calendar Time Counter with Binary/BCD and 12/24-Hour Formats

This block keeps the time of year: seconds, minutes, hours, weekday, day of month, month and a two-digit year. It also holds three alarm fields for seconds, minutes and hours. Each tick of the one-second input advances the time by one second, and the carry runs through every field in the same cycle. The stored values follow the coding chosen by the format inputs. One input picks plain binary or packed BCD, and it applies to time and alarm fields alike. A second input picks 24-hour form, or 12-hour form with bit 7 of the hour used as the PM marker.

Software loads any field through a simple write port. While the hold input is high, ticks are ignored, so a group of fields can be loaded without an advance landing between the writes. A format input changes only how the next advances are computed. The stored bytes are never converted, and software reprograms them after a format change. Each advance gives a one-cycle update pulse. When the new time matches the alarm, a one-cycle alarm pulse comes in the same cycle.

Top module: `rtc_calendar`

## Requirements
- R1: Seconds and minutes count 0 to 59. A field at 59 (or above) wraps to 0 on an advance and carries into the next field.
- R2: When fmt_bin is 1, fields hold plain binary. When fmt_bin is 0, fields hold packed BCD (tens digit in bits 7:4, units in bits 3:0), and the units digit carries into the tens digit (0x09 steps to 0x10).
- R3: When fmt_24h is 1, the hour counts 0 to 23. The step from 23 to 0 carries into the day fields.
- R4: When fmt_24h is 0, bits 6:0 of the hour hold 1 to 12 and bit 7 is 1 for PM. The step from 11 to 12 toggles bit 7. The step from 12 to 1 keeps it. Only the step from 11 PM to 12 AM carries into the day fields.
- R5: On a day carry, the weekday counts 1 to 7 and wraps to 1. The day of month wraps to 1 after the last day of its month: 30 for months 4, 6, 9 and 11; 29 for month 2 when the year value is divisible by 4 and 28 otherwise; 31 for all other months. The month wraps from 12 to 1, and the year wraps from 99 to 0.
- R6: While hold is 1, a tick has no effect on any field and gives no update pulse. Writes still take effect.
- R7: Changing fmt_bin or fmt_24h leaves every stored time and alarm byte unchanged.
- R8: A write sets the field at wr_addr to wr_data: 0 sec, 1 min, 2 hour, 3 weekday, 4 day of month, 5 month, 6 year, 7 alarm sec, 8 alarm min, 9 alarm hour. Addresses 10 to 15 change nothing. If a write and an advance fall in the same cycle, the written field takes wr_data and the other fields advance.
- R9: update_done is 1 for exactly one cycle per advance. It rises in the first cycle in which the advanced values are visible on the outputs.
- R10: alarm_hit goes high together with update_done when each alarm field either equals the new time field byte for byte or has bits 7:6 both set, which makes it a don't-care. It is never high without update_done.
- R11: After reset the time is 00:00:00 on weekday 1, day 1, month 1, year 0. All alarm fields are 0 and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| fmt_bin | input | 1 | 1 = binary coding, 0 = packed BCD |
| fmt_24h | input | 1 | 1 = 24-hour form, 0 = 12-hour form with PM in bit 7 |
| hold | input | 1 | Stops advancing while 1 |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 4 | Field selector for writes |
| wr_data | input | 8 | Value written to the selected field |
| tod_sec | output | 8 | Seconds |
| tod_min | output | 8 | Minutes |
| tod_hour | output | 8 | Hour |
| tod_wday | output | 8 | Weekday |
| tod_mday | output | 8 | Day of month |
| tod_month | output | 8 | Month |
| tod_year | output | 8 | Year in century |
| alm_sec | output | 8 | Alarm seconds |
| alm_min | output | 8 | Alarm minutes |
| alm_hour | output | 8 | Alarm hour |
| update_done | output | 1 | One-cycle pulse after each advance |
| alarm_hit | output | 1 | One-cycle pulse when the advanced time matches the alarm |

## Verification
A field write and a tick can land in the same cycle. This matters most when the write goes to an alarm field that the new time must be compared against. The bench provokes this by writing the alarm seconds in the very cycle that carries the seconds from 0x09 to 0x10. It expects alarm_hit together with update_done, because the comparison uses the value just written. It also checks a minute write that coincides with a tick: the written minute must win, and the seconds must still advance.

// File: rtl/rtc_calendar.sv
module rtc_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       fmt_bin,
  input  logic       fmt_24h,
  input  logic       hold,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] tod_sec,
  output logic [7:0] tod_min,
  output logic [7:0] tod_hour,
  output logic [7:0] tod_wday,
  output logic [7:0] tod_mday,
  output logic [7:0] tod_month,
  output logic [7:0] tod_year,
  output logic [7:0] alm_sec,
  output logic [7:0] alm_min,
  output logic [7:0] alm_hour,
  output logic       update_done,
  output logic       alarm_hit
);

  localparam int NF = 10;

  logic [7:0] cur [NF];
  logic [7:0] adv [NF];
  logic [7:0] nxt [NF];
  logic       match;

  wire step = sec_tick & ~hold;

  function automatic logic [6:0] dec(input logic [7:0] v, input logic b);
    return b ? v[6:0] : 7'(7'(v[7:4]) * 7'd10 + 7'(v[3:0]));
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] n, input logic b);
    return b ? {1'b0, n} : {4'(n / 7'd10), 4'(n % 7'd10)};
  endfunction

  function automatic logic al_ok(input logic [7:0] a, input logic [7:0] t);
    return (a[7:6] == 2'b11) || (a == t);
  endfunction

  always_comb begin : advance
    logic [6:0] s, m, h, d, dm, mo, y, dim, hn;
    logic       cs, cm, cd, cdm, cmo, pmn;
    s  = dec(cur[0], fmt_bin);
    m  = dec(cur[1], fmt_bin);
    d  = dec(cur[3], fmt_bin);
    dm = dec(cur[4], fmt_bin);
    mo = dec(cur[5], fmt_bin);
    y  = dec(cur[6], fmt_bin);
    cs = s >= 7'd59;
    cm = cs && (m >= 7'd59);
    adv[0] = enc(cs ? 7'd0 : s + 7'd1, fmt_bin);
    adv[1] = cs ? enc((m >= 7'd59) ? 7'd0 : m + 7'd1, fmt_bin) : cur[1];

    if (fmt_24h) begin
      h   = dec(cur[2], fmt_bin);
      hn  = (h >= 7'd23) ? 7'd0 : h + 7'd1;
      pmn = 1'b0;
      cd  = cm && (h >= 7'd23);
      adv[2] = cm ? enc(hn, fmt_bin) : cur[2];
    end else begin
      h   = dec({1'b0, cur[2][6:0]}, fmt_bin);
      pmn = cur[2][7];
      if (h >= 7'd12)      hn = 7'd1;
      else if (h == 7'd11) begin hn = 7'd12; pmn = ~cur[2][7]; end
      else                 hn = h + 7'd1;
      cd  = cm && (h == 7'd11) && cur[2][7];
      adv[2] = cm ? {pmn, enc(hn, fmt_bin)[6:0]} : cur[2];
    end

    case (mo)
      7'd2:                      dim = (y[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   dim = 7'd30;
      default:                   dim = 7'd31;
    endcase
    cdm = cd && (dm >= dim);
    cmo = cdm && (mo >= 7'd12);

    adv[3] = cd  ? enc((d  >= 7'd7)  ? 7'd1 : d  + 7'd1, fmt_bin) : cur[3];
    adv[4] = cd  ? enc((dm >= dim)   ? 7'd1 : dm + 7'd1, fmt_bin) : cur[4];
    adv[5] = cdm ? enc((mo >= 7'd12) ? 7'd1 : mo + 7'd1, fmt_bin) : cur[5];
    adv[6] = cmo ? enc((y  >= 7'd99) ? 7'd0 : y  + 7'd1, fmt_bin) : cur[6];
    adv[7] = cur[7];
    adv[8] = cur[8];
    adv[9] = cur[9];
  end

  always_comb begin
    for (int i = 0; i < NF; i++)
      nxt[i] = (wr_en && wr_addr == 4'(i)) ? wr_data : (step ? adv[i] : cur[i]);
  end

  assign match = al_ok(nxt[7], nxt[0]) && al_ok(nxt[8], nxt[1]) && al_ok(nxt[9], nxt[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++)
        cur[i] <= (i >= 3 && i <= 5) ? 8'h01 : 8'h00;
      update_done <= 1'b0;
      alarm_hit   <= 1'b0;
    end else begin
      for (int i = 0; i < NF; i++)
        cur[i] <= nxt[i];
      update_done <= step;
      alarm_hit   <= step && match;
    end
  end

  assign tod_sec   = cur[0];
  assign tod_min   = cur[1];
  assign tod_hour  = cur[2];
  assign tod_wday  = cur[3];
  assign tod_mday  = cur[4];
  assign tod_month = cur[5];
  assign tod_year  = cur[6];
  assign alm_sec   = cur[7];
  assign alm_min   = cur[8];
  assign alm_hour  = cur[9];

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    update_done && !$past(wr_en) && cur[0] == 8'h00 |-> dec($past(cur[0]), $past(fmt_bin)) >= 7'd59); // R1

  AST_WDAY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    update_done && !$past(wr_en) |-> cur[3] != 8'h00); // R5

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold) && !$past(wr_en) |-> cur[0] == $past(cur[0]) && !update_done); // R6

  AST_FMT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sec_tick) && !$past(wr_en) |-> $stable(cur[0]) && $stable(cur[2]) && $stable(cur[9])); // R7

  AST_ALARM_WITH_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> update_done); // R10

endmodule

// File: tb/rtc_calendar_bench.sv
`timescale 1ns/1ps
module rtc_calendar_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sec_tick = 1'b0, fmt_bin = 1'b0, fmt_24h = 1'b1, hold = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = 4'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] o_sec, o_min, o_hour, o_wday, o_mday, o_mon, o_year, a_sec, a_min, a_hour;
  logic upd, hit;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_calendar u_rtc_calendar (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .fmt_bin(fmt_bin), .fmt_24h(fmt_24h),
    .hold(hold), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tod_sec(o_sec), .tod_min(o_min), .tod_hour(o_hour), .tod_wday(o_wday),
    .tod_mday(o_mday), .tod_month(o_mon), .tod_year(o_year),
    .alm_sec(a_sec), .alm_min(a_min), .alm_hour(a_hour),
    .update_done(upd), .alarm_hit(hit));

  typedef struct packed {
    logic       b, h24;
    logic [55:0] pre;
    logic [55:0] exp;
  } vec_t;

  // fields packed as sec,min,hour,wday,mday,month,year
  localparam vec_t VEC [10] = '{
    '{1'b0, 1'b1, 56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_01_00}, // R1 R2 R3 R5 year/month wrap
    '{1'b1, 1'b1, 56'h3B_0A_05_03_0F_06_14, 56'h00_0B_05_03_0F_06_14}, // R1 R2 binary
    '{1'b0, 1'b0, 56'h59_59_11_02_10_03_24, 56'h00_00_92_02_10_03_24}, // R4 11AM->12PM
    '{1'b0, 1'b0, 56'h59_59_92_02_10_03_24, 56'h00_00_81_02_10_03_24}, // R4 12PM->1PM
    '{1'b0, 1'b0, 56'h59_59_91_04_28_02_23, 56'h00_00_12_05_01_03_23}, // R4 R5 11PM->12AM, Feb 28
    '{1'b0, 1'b1, 56'h59_59_23_06_28_02_24, 56'h00_00_00_07_29_02_24}, // R5 leap Feb
    '{1'b1, 1'b1, 56'h3B_3B_17_07_1E_04_05, 56'h00_00_00_01_01_05_05}, // R3 R5 30-day month
    '{1'b0, 1'b1, 56'h09_45_13_01_05_07_50, 56'h10_45_13_01_05_07_50}, // R2 BCD digit carry
    '{1'b1, 1'b0, 56'h3B_3B_0C_01_01_01_00, 56'h00_00_01_01_01_01_00}, // R4 binary 12AM->1AM
    '{1'b1, 1'b0, 56'h3B_3B_0B_01_01_01_00, 56'h00_00_8C_01_01_01_00}  // R4 binary 11AM->12PM
  };

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic we, input logic [3:0] a, input logic [7:0] d);
    sec_tick = t; wr_en = we; wr_addr = a; wr_data = d;
    @(negedge clk);
    sec_tick = 1'b0; wr_en = 1'b0;
  endtask

  function automatic logic [55:0] tod();
    return {o_sec, o_min, o_hour, o_wday, o_mday, o_mon, o_year};
  endfunction

  function automatic logic [79:0] all_f();
    return {tod(), a_sec, a_min, a_hour};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [79:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(all_f() == {56'h00_00_00_01_01_01_00, 24'h0} && !upd && !hit, "R11 reset state",
        {all_f()}, {56'h00_00_00_01_01_01_00, 24'h0});

    for (int i = 0; i < 10; i++) begin
      fmt_bin = VEC[i].b; fmt_24h = VEC[i].h24;
      for (int k = 0; k < 7; k++) step(1'b0, 1'b1, 4'(k), VEC[i].pre[55 - 8*k -: 8]);
      step(1'b1, 1'b0, 4'd0, 8'd0);
      chk(tod() == VEC[i].exp && upd, $sformatf("vector %0d R1 R2 R3 R4 R5 R9", i),
          {24'h0, tod()}, {24'h0, VEC[i].exp});
    end

    fmt_bin = 1'b0; fmt_24h = 1'b1;
    @(negedge clk);
    chk(!upd, "R9 update pulse lasts one cycle", 80'(upd), 80'd0);

    step(1'b0, 1'b1, 4'd0, 8'h20);
    hold = 1'b1;
    snap = all_f();
    step(1'b1, 1'b0, 4'd0, 8'd0);
    chk(all_f() == snap && !upd, "R6 tick ignored under hold", all_f(), snap);
    step(1'b0, 1'b1, 4'd1, 8'h33);
    chk(o_min == 8'h33, "R6 write under hold", 80'(o_min), 80'h33);
    hold = 1'b0;

    snap = all_f();
    fmt_bin = 1'b1; fmt_24h = 1'b0;
    repeat (2) @(negedge clk);
    chk(all_f() == snap, "R7 format change keeps values", all_f(), snap);
    fmt_bin = 1'b0; fmt_24h = 1'b1;

    step(1'b0, 1'b1, 4'd12, 8'hAA);
    chk(all_f() == snap, "R8 unused address ignored", all_f(), snap);

    step(1'b0, 1'b1, 4'd0, 8'h30);
    step(1'b1, 1'b1, 4'd1, 8'h07);
    chk(o_sec == 8'h31 && o_min == 8'h07, "R8 write beside tick",
        80'({o_sec, o_min}), 80'h3107);

    step(1'b0, 1'b1, 4'd7, 8'h05);
    step(1'b0, 1'b1, 4'd8, 8'hC0);
    step(1'b0, 1'b1, 4'd9, 8'hC3);
    step(1'b0, 1'b1, 4'd0, 8'h04);
    step(1'b1, 1'b0, 4'd0, 8'd0);
    chk(hit && upd && o_sec == 8'h05, "R10 alarm with don't-care fields",
        80'({hit, upd, o_sec}), 80'({2'b11, 8'h05}));
    @(negedge clk);
    chk(!hit && !upd, "R9 R10 pulses drop", 80'({hit, upd}), 80'd0);
    step(1'b1, 1'b0, 4'd0, 8'd0);
    chk(!hit && upd && o_sec == 8'h06, "R10 no alarm on mismatch",
        80'({hit, upd, o_sec}), 80'({2'b01, 8'h06}));

    step(1'b0, 1'b1, 4'd2, 8'h07);
    step(1'b0, 1'b1, 4'd9, 8'h08);
    step(1'b0, 1'b1, 4'd0, 8'h04);
    step(1'b1, 1'b0, 4'd0, 8'd0);
    chk(!hit && upd, "R10 exact hour mismatch", 80'({hit, upd}), 80'b01);
    step(1'b0, 1'b1, 4'd9, 8'h07);
    step(1'b0, 1'b1, 4'd7, 8'h06);
    step(1'b1, 1'b0, 4'd0, 8'd0);
    chk(hit, "R10 exact hour match", 80'(hit), 80'd1);

    step(1'b0, 1'b1, 4'd9, 8'hFF);
    step(1'b0, 1'b1, 4'd0, 8'h09);
    step(1'b1, 1'b1, 4'd7, 8'h10);
    chk(hit && upd && o_sec == 8'h10 && a_sec == 8'h10, "R8 R10 alarm written in tick cycle",
        80'({hit, upd, o_sec, a_sec}), 80'({2'b11, 8'h10, 8'h10}));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule